// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Register Writes

This block is a watchdog peripheral that sits on a simple word-addressed register bus. A 32-bit up-counter starts from a programmable load value and advances on a slow time base. The slow time base arrives as a one-cycle enable pulse (`tick_i`), typically at 32 kHz, and can be divided further by an optional power-of-two prescaler. When the counter runs past all ones while the timer is running, the block emits a one-cycle reset request and starts again from the load value. Software keeps the system alive by writing a new value to the trigger register, which reloads the counter.

Writes to the control, load, trigger and key registers are posted. The bus write finishes at once, but the new value takes effect only after a fixed number of slow ticks. Until then a per-register pending flag is visible in the status register. Starting and stopping the timer each take two key words written in order. A broken pair is thrown away.

Register addresses (word index on `bus_addr_i`): 0 revision, 1 control, 2 counter, 3 load, 4 trigger, 5 key, 6 pending status. Reads of any other address return zero.

Top module: `wdog_regblock`

## Requirements
- R1: After reset the timer is stopped, `wdt_rst_o` is low, and the pending status reads 0. The control register reads 0, and both the counter and the load register read `LOAD_RST`.
- R2: Reading address 0 returns `REV_CODE` in bits 7:0 and zero in bits 31:8.
- R3: A write to control, load, trigger or key sets status bit 0, 2, 3 or 4 respectively from the next clock cycle. The new value takes effect, and the bit clears, on the `POST_TICKS`-th (default 2) `tick_i` pulse after the write. Until then the old value is read back.
- R4: A write to a register whose pending bit is set is dropped. Only the first value takes effect.
- R5: Key word 0x0000BBBB followed by the next key word 0x00004444 starts the timer. The counter first advances on the tick after the one that applied 0x4444.
- R6: Key word 0x0000AAAA followed by the next key word 0x00005555 stops the timer. The counter still advances on the tick that applies 0x5555, and holds after that.
- R7: If the key word after a first key word is not its matching second word, the pair is discarded and the run state is unchanged.
- R8: When an applied trigger write differs from the previous trigger value, the counter reloads from the load register on that tick. An applied trigger value equal to the previous one has no effect on the counter.
- R9: A reloading trigger write while stopped sets the counter to the load value, and the counter stays there through further ticks.
- R10: With control bit 5 clear, the running counter advances by one on every tick. With bit 5 set, it advances once every 2^N ticks, where N is control bits 4:2. The prescale phase restarts on every trigger reload.
- R11: When the running counter advances from all ones, `wdt_rst_o` is high for exactly one clock cycle, and in that cycle the counter holds the load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle slow time-base pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset request on counter overflow |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse synchronous to `clk`. They also assume that bus writes are one-cycle strobes and that the address is stable while the strobe is high. The bench drives every input on the falling clock edge and raises `tick_i` only for one cycle at a time. It never asserts a write strobe and a tick in the same cycle, so each posted write sees exactly `POST_TICKS` ticks before it applies. Counter values are predicted by counting ticks from the tick that applied the most recent start, stop or reload.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int NSLOT  = 4;
    localparam int STAT_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_REV   = 3'd0,
        RA_CTRL  = 3'd1,
        RA_COUNT = 3'd2,
        RA_LOAD  = 3'd3,
        RA_TRIG  = 3'd4,
        RA_KEY   = 3'd5,
        RA_STAT  = 3'd6
    } reg_addr_e;

    // posted slot indices
    localparam int SL_CTRL = 0;
    localparam int SL_LOAD = 1;
    localparam int SL_TRIG = 2;
    localparam int SL_KEY  = 3;

    localparam logic [DATA_W-1:0] KEY_RUN_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_RUN_B  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_RUN_ARMED,
        KS_HALT_ARMED
    } key_state_e;

    typedef struct packed {
        logic       psc_en;
        logic [2:0] psc_exp;
    } psc_cfg_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            SL_CTRL: return RA_CTRL;
            SL_LOAD: return RA_LOAD;
            SL_TRIG: return RA_TRIG;
            default: return RA_KEY;
        endcase
    endfunction

    function automatic int slot_stat_bit(input int idx);
        case (idx)
            SL_CTRL: return 0;
            SL_LOAD: return 2;
            SL_TRIG: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic psc_cfg_t decode_ctrl(input logic [DATA_W-1:0] w);
        psc_cfg_t c;
        c.psc_en  = w[5];
        c.psc_exp = w[4:2];
        return c;
    endfunction

endpackage

// File: rtl/wdog_post_slot.sv
module wdog_post_slot #(
    parameter int DW         = 32,
    parameter int POST_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          apply,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(POST_TICKS + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(POST_TICKS);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [CW-1:0] left_q;

    assign apply = busy && tick && (left_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            left_q <= '0;
            data   <= '0;
        end else if (!busy) begin
            if (wr_hit) begin
                busy   <= 1'b1;
                left_q <= CNT_INIT;
                data   <= wdata;
            end
        end else if (tick) begin
            if (left_q == CNT_LAST) begin
                busy   <= 1'b0;
                left_q <= '0;
            end else begin
                left_q <= left_q - CNT_LAST;
            end
        end
    end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  logic [DATA_W-1:0] word,
    output logic              run
);
    key_state_e st_q, st_d;
    logic       run_d;

    always_comb begin
        st_d  = st_q;
        run_d = run;
        if (apply) begin
            unique case (st_q)
                KS_RUN_ARMED: begin
                    if (word == KEY_RUN_B) begin
                        run_d = 1'b1;
                        st_d  = KS_IDLE;
                    end else if (word == KEY_RUN_A) begin
                        st_d = KS_RUN_ARMED;
                    end else if (word == KEY_HALT_A) begin
                        st_d = KS_HALT_ARMED;
                    end else begin
                        st_d = KS_IDLE;
                    end
                end
                KS_HALT_ARMED: begin
                    if (word == KEY_HALT_B) begin
                        run_d = 1'b0;
                        st_d  = KS_IDLE;
                    end else if (word == KEY_RUN_A) begin
                        st_d = KS_RUN_ARMED;
                    end else if (word == KEY_HALT_A) begin
                        st_d = KS_HALT_ARMED;
                    end else begin
                        st_d = KS_IDLE;
                    end
                end
                default: begin
                    if (word == KEY_RUN_A)
                        st_d = KS_RUN_ARMED;
                    else if (word == KEY_HALT_A)
                        st_d = KS_HALT_ARMED;
                    else
                        st_d = KS_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KS_IDLE;
            run  <= 1'b0;
        end else begin
            st_q <= st_d;
            run  <= run_d;
        end
    end
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core
    import wdog_pkg::*;
#(
    parameter int              CNT_W    = 32,
    parameter logic [CNT_W-1:0] LOAD_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  psc_cfg_t         cfg,
    input  logic [CNT_W-1:0] load,
    input  logic             reload,
    output logic [CNT_W-1:0] count,
    output logic             wrst
);
    localparam int PSC_W = 7;
    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] psc_lim;
    logic             psc_done;
    logic             at_top;

    assign psc_lim  = (PSC_ONE << cfg.psc_exp) - PSC_ONE;
    assign psc_done = !cfg.psc_en || (psc_q >= psc_lim);
    assign at_top   = &count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= LOAD_RST;
            psc_q <= '0;
            wrst  <= 1'b0;
        end else begin
            wrst <= 1'b0;
            if (reload) begin
                count <= load;
                psc_q <= '0;
            end else if (run && tick) begin
                if (psc_done) begin
                    psc_q <= '0;
                    if (at_top) begin
                        count <= load;
                        wrst  <= 1'b1;
                    end else begin
                        count <= count + CNT_W'(1);
                    end
                end else begin
                    psc_q <= psc_q + PSC_ONE;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_regblock.sv
module wdog_regblock
    import wdog_pkg::*;
#(
    parameter int                POST_TICKS = 2,
    parameter logic [7:0]        REV_CODE   = 8'h31,
    parameter logic [DATA_W-1:0] LOAD_RST   = 32'hFFFF_8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wdt_rst_o
);
    logic              slot_busy  [NSLOT];
    logic              slot_apply [NSLOT];
    logic [DATA_W-1:0] slot_data  [NSLOT];

    logic [STAT_W-1:0] stat_vec;
    logic [DATA_W-1:0] ctrl_q, load_q, trig_q, count_q;
    logic              run_q;
    logic              trig_reload;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        wdog_post_slot #(
            .DW        (DATA_W),
            .POST_TICKS(POST_TICKS)
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_i),
            .wr_hit(bus_wr_i && (bus_addr_i == slot_addr(i))),
            .wdata (bus_wdata_i),
            .busy  (slot_busy[i]),
            .apply (slot_apply[i]),
            .data  (slot_data[i])
        );
    end

    always_comb begin
        stat_vec = '0;
        for (int i = 0; i < NSLOT; i++)
            stat_vec[slot_stat_bit(i)] = slot_busy[i];
    end

    assign trig_reload = slot_apply[SL_TRIG] && (slot_data[SL_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= LOAD_RST;
            trig_q <= '0;
        end else begin
            if (slot_apply[SL_CTRL]) ctrl_q <= slot_data[SL_CTRL];
            if (slot_apply[SL_LOAD]) load_q <= slot_data[SL_LOAD];
            if (slot_apply[SL_TRIG]) trig_q <= slot_data[SL_TRIG];
        end
    end

    wdog_key_seq u_key (
        .clk  (clk),
        .rst  (rst),
        .apply(slot_apply[SL_KEY]),
        .word (slot_data[SL_KEY]),
        .run  (run_q)
    );

    wdog_count_core #(
        .CNT_W   (DATA_W),
        .LOAD_RST(LOAD_RST)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_i),
        .run   (run_q),
        .cfg   (decode_ctrl(ctrl_q)),
        .load  (load_q),
        .reload(trig_reload),
        .count (count_q),
        .wrst  (wdt_rst_o)
    );

    always_comb begin
        unique case (bus_addr_i)
            RA_REV:   bus_rdata_o = {{(DATA_W-8){1'b0}}, REV_CODE};
            RA_CTRL:  bus_rdata_o = ctrl_q;
            RA_COUNT: bus_rdata_o = count_q;
            RA_LOAD:  bus_rdata_o = load_q;
            RA_TRIG:  bus_rdata_o = trig_q;
            RA_STAT:  bus_rdata_o = {{(DATA_W-STAT_W){1'b0}}, stat_vec};
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog_regblock_chk.sv
module wdog_regblock_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STAT_W-1:0] stat,
    input logic              run,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load,
    input logic              reload,
    input logic              key_apply,
    input logic              wrst
);
    // R3
    ctrl_pending_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_CTRL && !stat[0]) |=> stat[0]);

    // R3
    load_pending_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_LOAD && !stat[2]) |=> stat[2]);

    // R5
    run_only_by_key_chk: assert property (@(posedge clk) disable iff (rst)
        !key_apply |=> $stable(run));

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(count));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !reload) |=> $stable(count));

    // R11
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        wrst |=> !wrst);

    // R11
    rst_reload_chk: assert property (@(posedge clk) disable iff (rst)
        wrst |-> (count == load));
endmodule

bind wdog_regblock wdog_regblock_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .bus_wr   (bus_wr_i),
    .bus_addr (bus_addr_i),
    .stat     (stat_vec),
    .run      (run_q),
    .count    (count_q),
    .load     (load_q),
    .reload   (trig_reload),
    .key_apply(slot_apply[SL_KEY]),
    .wrst     (wdt_rst_o)
);

// File: tb/wdog_regblock_tb.sv
module wdog_regblock_tb;
    import wdog_pkg::*;

    localparam logic [7:0]  REV  = 8'h31;
    localparam logic [31:0] LRST = 32'hFFFF_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        wdt_rst_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    wdog_regblock #(.POST_TICKS(2), .REV_CODE(REV), .LOAD_RST(LRST)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o)
    );

    always @(posedge clk) if (!rst && wdt_rst_o) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic key(input logic [31:0] w);
        wr(RA_KEY, w);
        tk(2);
    endtask

    task automatic expect_count(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(RA_COUNT, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(RA_STAT, v);  chk("R1 status", v, 32'h0);
        rd(RA_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(RA_LOAD, v);  chk("R1 load", v, LRST);
        expect_count("R1 count", LRST);
        chk("R1 wdt_rst", {31'h0, wdt_rst_o}, 32'h0);
        tk(2);
        expect_count("R1 stopped after reset", LRST);
        rd(RA_REV, v);
        chk("R2 revision code", {24'h0, v[7:0]}, {24'h0, REV});
        chk("R2 upper zero", {8'h0, v[31:8]}, 32'h0);
    endtask

    task automatic t_posted;
        logic [31:0] v;
        wr(RA_LOAD, 32'h100);
        rd(RA_STAT, v); chk("R3 load pending bit2", v, 32'h4);
        rd(RA_LOAD, v); chk("R3 old load visible", v, LRST);
        tk(1);
        rd(RA_STAT, v); chk("R3 still pending after 1 tick", v, 32'h4);
        tk(1);
        rd(RA_STAT, v); chk("R3 pending cleared", v, 32'h0);
        rd(RA_LOAD, v); chk("R3 load applied", v, 32'h100);
        wr(RA_CTRL, 32'h0);
        rd(RA_STAT, v); chk("R3 ctrl pending bit0", v, 32'h1);
        tk(2);
        wr(RA_TRIG, 32'h0);
        rd(RA_STAT, v); chk("R3 trig pending bit3", v, 32'h8);
        tk(2);
        wr(RA_KEY, 32'h0);
        rd(RA_STAT, v); chk("R3 key pending bit4", v, 32'h10);
        tk(2);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        wr(RA_LOAD, 32'h200);
        wr(RA_LOAD, 32'h300);
        tk(2);
        rd(RA_LOAD, v); chk("R4 second write dropped", v, 32'h200);
    endtask

    task automatic t_trig_stopped;
        wr(RA_TRIG, 32'h1); tk(2);
        expect_count("R9 reload while stopped", 32'h200);
        tk(3);
        expect_count("R9 no counting while stopped", 32'h200);
    endtask

    task automatic t_start;
        key(KEY_RUN_A); key(KEY_RUN_B);
        expect_count("R5 no advance on start tick", 32'h200);
        tk(3);
        expect_count("R5 running advances", 32'h203);
    endtask

    task automatic t_trig_same;
        wr(RA_TRIG, 32'h1); tk(2);
        expect_count("R8 same trigger no reload", 32'h205);
        wr(RA_TRIG, 32'h2); tk(2);
        expect_count("R8 new trigger reloads", 32'h200);
        tk(1);
        expect_count("R10 unscaled one per tick", 32'h201);
    endtask

    task automatic t_broken;
        key(KEY_HALT_A); key(32'h1234); key(KEY_HALT_B);
        tk(1);
        expect_count("R7 broken stop pair ignored", 32'h208);
    endtask

    task automatic t_stop;
        key(KEY_HALT_A); key(KEY_HALT_B);
        expect_count("R6 advance on stop tick", 32'h20C);
        tk(3);
        expect_count("R6 held after stop", 32'h20C);
        key(KEY_RUN_A); key(32'h7777); key(KEY_RUN_B);
        tk(2);
        expect_count("R7 broken start pair ignored", 32'h20C);
    endtask

    task automatic t_psc;
        wr(RA_CTRL, 32'h28); tk(2);
        wr(RA_TRIG, 32'h3); tk(2);
        key(KEY_RUN_A); key(KEY_RUN_B);
        tk(3);
        expect_count("R10 prescaled hold for 3 ticks", 32'h200);
        tk(1);
        expect_count("R10 prescaled step on 4th tick", 32'h201);
        tk(4);
        expect_count("R10 prescaled second step", 32'h202);
        key(KEY_HALT_A); key(KEY_HALT_B);
        expect_count("R10 prescaled during stop", 32'h203);
        wr(RA_CTRL, 32'h0); tk(2);
    endtask

    task automatic t_overflow;
        wr(RA_LOAD, 32'hFFFF_FFFE); tk(2);
        wr(RA_TRIG, 32'h4); tk(2);
        expect_count("R11 preload", 32'hFFFF_FFFE);
        key(KEY_RUN_A); key(KEY_RUN_B);
        tk(1);
        expect_count("R11 at top", 32'hFFFF_FFFF);
        chk("R11 no pulse before overflow", {31'h0, wdt_rst_o}, 32'h0);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        chk("R11 pulse high", {31'h0, wdt_rst_o}, 32'h1);
        chk("R11 reloaded in pulse cycle", bus_rdata_o, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R11 pulse one cycle", {31'h0, wdt_rst_o}, 32'h0);
        chk("R11 pulse count", pulses, 32'd1);
        tk(1);
        expect_count("R11 keeps running", 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_posted();
        t_drop();
        t_trig_stopped();
        t_start();
        t_trig_same();
        t_broken();
        t_stop();
        t_psc();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule